// File: doc/BRIEF.md
# Frame-to-Frame Memory Change Detector

This block sits beside a switching memory that is read out word by word, one word per clock, in a fixed frame. It folds every word read during a frame into a 16-bit cyclic redundancy code. When the next frame pulse arrives, it sets that frame's code against the code of the frame before. A difference means the stored image changed by some path other than the host. In that case a sticky change-detect flag is pulled low, in the manner of an open-drain line. Frames in which the host wrote the memory are exempt, and so is the frame after them. Frames of the wrong length are also exempt. The host releases the flag by strobing the data strobe while chip select is active.

The control path is a three-state machine. `CD_IDLE` waits for the first frame pulse after reset. `CD_PRIME` collects a frame whose code will become the reference. `CD_RUN` compares each finished frame against the reference. The transitions are named as follows. *start* (IDLE to PRIME) fires on the first frame pulse. *arm* (PRIME to RUN) fires on a frame pulse that ends a frame of correct length, and loads the reference. *reprime* (PRIME to PRIME, or RUN to PRIME) fires on a frame pulse that ends a frame of wrong length, and loads nothing. *compare* (RUN to RUN) fires on a frame pulse that ends a frame of correct length. It compares the codes unless a host write masks the frame, and it always reloads the reference.

Top module: `cdet_top`

## Requirements
- R1: A clock edge that samples `frame_n` low marks the word on `rd_word` in that cycle as the first word of a new frame and ends the previous frame. Every other cycle adds its word to the current frame.
- R2: Each frame's code is CRC-16 with polynomial 0x1021 and start value 0xFFFF. Each 16-bit word is folded in most significant bit first. On the edge that ends a compared frame, `cd_n` goes low (0) if that frame's code differs from the code of the frame before it.
- R3: Once low, `cd_n` stays low until a valid clear, regardless of later frames.
- R4: An edge that samples both `cs_n` and `ds_n` low releases `cd_n` to 1. If `ds_n` is low while `cs_n` is high, the flag does not change.
- R5: If a mismatch and a valid clear fall on the same edge, `cd_n` stays low.
- R6: A `host_wr` pulse in frame k removes the comparison at the end of frame k and at the end of frame k+1. The reference is still reloaded, so a change written by the host never pulls `cd_n` low.
- R7: Reset drives `cd_n` to 1. The first frame pulse after reset only starts collection. The second frame pulse loads the reference. The first comparison happens at the third frame pulse.
- R8: A frame whose length differs from FRAME_LEN words is neither compared nor used as the reference. The next frame of correct length becomes the new reference.
- R9: Frames with identical contents never pull `cd_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one memory word per rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_n | input | 1 | Frame pulse, active low, marks the first word of a frame |
| rd_word | input | DATA_W | Word read from the memory in this cycle |
| host_wr | input | 1 | High in a cycle where the host writes the memory |
| cs_n | input | 1 | Chip select, active low |
| ds_n | input | 1 | Data strobe, active low |
| cd_n | output | 1 | Change detect, 0 = pulled low (change seen), 1 = released |

## Verification
The bench steps a modelled memory image through a series of frames, with FRAME_LEN reduced for speed.

- Runs of identical frames confirm that a stable image stays quiet.
- A single flipped word, with no host write, must raise the flag one frame pulse after the frame that carried it. This is tried at the first, a middle and the last word position.
- Host writes are placed both before and after the read of the word they change. This separates a mask that covers only the frame of the write from one that also covers the frame after it.
- Short and long frames, and the frames right after reset, check that unreliable codes never act as a reference.
- Strobes with and without chip select, and a strobe on the same edge as a new mismatch, pin down the clear rules.

// File: rtl/cdet_pkg.sv
package cdet_pkg;

    typedef enum logic [1:0] {
        CD_IDLE  = 2'd0,
        CD_PRIME = 2'd1,
        CD_RUN   = 2'd2
    } cd_state_e;

    typedef enum logic [2:0] {
        V_NONE     = 3'd0,
        V_START    = 3'd1,
        V_ARM      = 3'd2,
        V_REPRIME  = 3'd3,
        V_COMPARE  = 3'd4,
        V_MASKED   = 3'd5
    } cd_verdict_e;

endpackage

// File: rtl/cdet_crc_acc.sv
module cdet_crc_acc #(
    parameter int              DATA_W = 16,
    parameter int              CRC_W  = 16,
    parameter logic [CRC_W-1:0] POLY  = 16'h1021,
    parameter logic [CRC_W-1:0] INIT  = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bnd,
    input  logic [DATA_W-1:0] word,
    output logic [CRC_W-1:0]  crc_q
);

    function automatic logic [CRC_W-1:0] crc_fold(
        input logic [CRC_W-1:0]  c,
        input logic [DATA_W-1:0] d
    );
        logic [CRC_W-1:0] r;
        logic             fb;
        r = c;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb = r[CRC_W-1] ^ d[i];
            r  = {r[CRC_W-2:0], 1'b0};
            if (fb) r = r ^ POLY;
        end
        return r;
    endfunction

    logic [CRC_W-1:0] seed;
    assign seed = bnd ? INIT : crc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) crc_q <= INIT;
        else        crc_q <= crc_fold(seed, word);
    end

    // R1: a frame restarts from the start value, so the code after a boundary
    // depends only on the boundary word
    assert_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd && $past(bnd) && $past(word) == word && rst_n && $past(rst_n)) |=> $stable(crc_q));

endmodule

// File: rtl/cdet_len_track.sv
module cdet_len_track #(
    parameter int FRAME_LEN = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bnd,
    output logic len_ok
);

    localparam int CNT_MAX = FRAME_LEN + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (bnd)                        cnt_q <= CNT_W'(1);
        else if (cnt_q != CNT_W'(CNT_MAX))   cnt_q <= cnt_q + 1'b1;
    end

    assign len_ok = (cnt_q == CNT_W'(FRAME_LEN));

    // R8: the boundary word is word one of the new frame
    assert_len_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bnd |=> (cnt_q == CNT_W'(1)));

    // R8: the count never runs past its saturation value
    assert_len_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_W'(CNT_MAX) && !bnd) |=> (cnt_q == CNT_W'(CNT_MAX)));

endmodule

// File: rtl/cdet_host_mask.sv
module cdet_host_mask (
    input  logic clk,
    input  logic rst_n,
    input  logic bnd,
    input  logic host_wr,
    output logic skip
);

    logic wr_cur_q;
    logic wr_prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_cur_q  <= 1'b0;
            wr_prev_q <= 1'b0;
        end else if (bnd) begin
            wr_prev_q <= wr_cur_q;
            wr_cur_q  <= host_wr;
        end else if (host_wr) begin
            wr_cur_q  <= 1'b1;
        end
    end

    assign skip = wr_cur_q | wr_prev_q;

    // R6: a write inside a frame keeps the mask up across the next boundary
    assert_mask_two_frames_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd && wr_cur_q) |=> skip);

endmodule

// File: rtl/cdet_ctrl.sv
module cdet_ctrl
    import cdet_pkg::*;
#(
    parameter int CRC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bnd,
    input  logic             len_ok,
    input  logic             skip,
    input  logic [CRC_W-1:0] crc_q,
    input  logic             clear_req,
    output logic             cd_flag
);

    cd_state_e        state_q, state_d;
    cd_verdict_e      verdict;
    logic [CRC_W-1:0] ref_q;
    logic             ref_load;
    logic             set_evt;

    // verdict and next state
    always_comb begin
        state_d = state_q;
        verdict = V_NONE;
        if (bnd) begin
            unique case (state_q)
                CD_IDLE: begin
                    verdict = V_START;
                    state_d = CD_PRIME;
                end
                CD_PRIME: begin
                    if (len_ok) begin
                        verdict = V_ARM;
                        state_d = CD_RUN;
                    end else begin
                        verdict = V_REPRIME;
                        state_d = CD_PRIME;
                    end
                end
                CD_RUN: begin
                    if (!len_ok) begin
                        verdict = V_REPRIME;
                        state_d = CD_PRIME;
                    end else if (skip) begin
                        verdict = V_MASKED;
                        state_d = CD_RUN;
                    end else begin
                        verdict = V_COMPARE;
                        state_d = CD_RUN;
                    end
                end
                default: begin
                    verdict = V_START;
                    state_d = CD_PRIME;
                end
            endcase
        end
    end

    assign ref_load = (verdict == V_ARM) || (verdict == V_COMPARE) || (verdict == V_MASKED);
    assign set_evt  = (verdict == V_COMPARE) && (crc_q != ref_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CD_IDLE;
        else        state_q <= state_d;
    end

    // outputs: reference and sticky flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q   <= '0;
            cd_flag <= 1'b0;
        end else begin
            if (ref_load) ref_q <= crc_q;
            if (set_evt)        cd_flag <= 1'b1;
            else if (clear_req) cd_flag <= 1'b0;
        end
    end

    // R2: flag rises only on a compared boundary with differing codes
    assert_rise_on_mismatch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cd_flag) |-> $past(bnd && state_q == CD_RUN && len_ok && !skip && crc_q != ref_q));

    // R3: flag holds without a clear request
    assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cd_flag && !clear_req) |=> cd_flag);

    // R4: a clear away from any boundary releases the flag
    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_req && !bnd) |=> !cd_flag);

    // R5: a mismatch on the clear edge wins
    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd && state_q == CD_RUN && len_ok && !skip && crc_q != ref_q) |=> cd_flag);

    // R6: masked boundaries never raise the flag
    assert_host_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd && skip && !cd_flag) |=> !cd_flag);

    // R7: no comparison before a reference exists
    assert_no_early_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != CD_RUN && !cd_flag) |=> !cd_flag);

    // R8: a frame of wrong length always sends the machine back to priming
    assert_bad_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd && !len_ok && state_q != CD_IDLE) |=> (state_q == CD_PRIME));

endmodule

// File: rtl/cdet_top.sv
module cdet_top #(
    parameter int               FRAME_LEN = 2048,
    parameter int               DATA_W    = 16,
    parameter int               CRC_W     = 16,
    parameter logic [CRC_W-1:0] POLY      = 16'h1021,
    parameter logic [CRC_W-1:0] INIT      = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic [DATA_W-1:0] rd_word,
    input  logic              host_wr,
    input  logic              cs_n,
    input  logic              ds_n,
    output logic              cd_n
);

    logic             bnd;
    logic             clear_req;
    logic [CRC_W-1:0] crc_q;
    logic             len_ok;
    logic             skip;
    logic             cd_flag;

    assign bnd       = ~frame_n;
    assign clear_req = ~cs_n & ~ds_n;

    cdet_crc_acc #(
        .DATA_W (DATA_W),
        .CRC_W  (CRC_W),
        .POLY   (POLY),
        .INIT   (INIT)
    ) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .bnd   (bnd),
        .word  (rd_word),
        .crc_q (crc_q)
    );

    cdet_len_track #(
        .FRAME_LEN (FRAME_LEN)
    ) u_len (
        .clk    (clk),
        .rst_n  (rst_n),
        .bnd    (bnd),
        .len_ok (len_ok)
    );

    cdet_host_mask u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .bnd     (bnd),
        .host_wr (host_wr),
        .skip    (skip)
    );

    cdet_ctrl #(
        .CRC_W (CRC_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bnd       (bnd),
        .len_ok    (len_ok),
        .skip      (skip),
        .crc_q     (crc_q),
        .clear_req (clear_req),
        .cd_flag   (cd_flag)
    );

    assign cd_n = ~cd_flag;

    // R4: a strobe without chip select leaves the output unchanged off a boundary
    assert_no_cs_no_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && frame_n && !cd_n) |=> !cd_n);

endmodule

// File: tb/cdet_top_bench.sv
module cdet_top_bench;

    localparam int FL   = 16;
    localparam int NONE = 255;

    typedef struct packed {
        logic [7:0] len;
        logic [7:0] mod_i;
        logic [7:0] hw_i;
        logic       hw_pre;
        logic [7:0] clr_i;
        logic       clr_cs;
        logic       exp_s;
        logic       exp_e;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 24;
    // fields: len, flipped word, host write word, write-before-read, strobe cycle,
    // chip select with strobe, cd_n after boundary, cd_n at frame end, requirement
    localparam vec_t TBL [NV] = '{
        '{8'd16, 8'd255, 8'd255, 1'b0, 8'd255, 1'b0, 1'b1, 1'b1, 4'd7}, // R7 boundary one
        '{8'd16, 8'd255, 8'd255, 1'b0, 8'd255, 1'b0, 1'b1, 1'b1, 4'd7}, // R7 boundary two
        '{8'd16, 8'd255, 8'd255, 1'b0, 8'd255, 1'b0, 1'b1, 1'b1, 4'd9}, // R9 same image
        '{8'd16, 8'd5,   8'd255, 1'b0, 8'd255, 1'b0, 1'b1, 1'b1, 4'd9}, // R9, flip word 5
        '{8'd16, 8'd255, 8'd255, 1'b0, 8'd255, 1'b0, 1'b0, 1'b0, 4'd2}, // R2 detected
        '{8'd16, 8'd255, 8'd255, 1'b0, 8'd3,   1'b1, 1'b0, 1'b1, 4'd4}, // R3 then R4 clear
        '{8'd16, 8'd255, 8'd9,   1'b0, 8'd255, 1'b0, 1'b1, 1'b1, 4'd6}, // R6 write after read
        '{8'd16, 8'd255, 8'd255, 1'b0, 8'd255, 1'b0, 1'b1, 1'b1, 4'd6}, // R6
        '{8'd16, 8'd255, 8'd2,   1'b1, 8'd255, 1'b0, 1'b1, 1'b1, 4'd6}, // R6 second frame masked
        '{8'd16, 8'd255, 8'd255, 1'b0, 8'd255, 1'b0, 1'b1, 1'b1, 4'd6}, // R6 write before read
        '{8'd16, 8'd255, 8'd255, 1'b0, 8'd255, 1'b0, 1'b1, 1'b1, 4'd6}, // R6
        '{8'd10, 8'd255, 8'd255, 1'b0, 8'd255, 1'b0, 1'b1, 1'b1, 4'd9}, // R9, short frame
        '{8'd16, 8'd255, 8'd255, 1'b0, 8'd255, 1'b0, 1'b1, 1'b1, 4'd8}, // R8 short not compared
        '{8'd16, 8'd0,   8'd255, 1'b0, 8'd255, 1'b0, 1'b1, 1'b1, 4'd8}, // R8 prime, flip word 0
        '{8'd16, 8'd4,   8'd255, 1'b0, 8'd255, 1'b0, 1'b0, 1'b0, 4'd2}, // R2 first word change
        '{8'd16, 8'd255, 8'd255, 1'b0, 8'd0,   1'b1, 1'b0, 1'b0, 4'd5}, // R5 set beats clear
        '{8'd16, 8'd255, 8'd255, 1'b0, 8'd3,   1'b0, 1'b0, 1'b0, 4'd4}, // R4 no chip select
        '{8'd16, 8'd255, 8'd255, 1'b0, 8'd3,   1'b1, 1'b0, 1'b1, 4'd4}, // R4 clear
        '{8'd20, 8'd7,   8'd255, 1'b0, 8'd255, 1'b0, 1'b1, 1'b1, 4'd3}, // R3 quiet, long frame
        '{8'd16, 8'd255, 8'd255, 1'b0, 8'd255, 1'b0, 1'b1, 1'b1, 4'd8}, // R8 long not compared
        '{8'd16, 8'd255, 8'd255, 1'b0, 8'd255, 1'b0, 1'b1, 1'b1, 4'd8}, // R8 rearmed
        '{8'd16, 8'd255, 8'd255, 1'b0, 8'd255, 1'b0, 1'b1, 1'b1, 4'd9}, // R9
        '{8'd16, 8'd15,  8'd255, 1'b0, 8'd255, 1'b0, 1'b1, 1'b1, 4'd1}, // R1 flip last word
        '{8'd16, 8'd255, 8'd255, 1'b0, 8'd255, 1'b0, 1'b0, 1'b0, 4'd1}  // R1 last word counted
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1;
    logic [15:0] rd_word = '0;
    logic        host_wr = 1'b0;
    logic        cs_n = 1'b1;
    logic        ds_n = 1'b1;
    logic        cd_n;

    logic [15:0] mem [FL];
    int          n_chk = 0;
    int          n_bad = 0;
    int          cyc = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cdet_top #(.FRAME_LEN(FL)) u_cdet_top (
        .clk     (clk),
        .rst_n   (rst_n),
        .frame_n (frame_n),
        .rd_word (rd_word),
        .host_wr (host_wr),
        .cs_n    (cs_n),
        .ds_n    (ds_n),
        .cd_n    (cd_n)
    );

    task automatic check(input logic exp, input int rq, input string what);
        n_chk++;
        if (cd_n !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: cd_n=%b expected %b", rq, what, cd_n, exp);
        end
    endtask

    task automatic junk(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            frame_n = 1'b1;
            rd_word = 16'(i * 16'h3C71 + 16'h0BAD);
            host_wr = 1'b0;
            cs_n = 1'b1;
            ds_n = 1'b1;
        end
    endtask

    task automatic do_frame(input vec_t v);
        for (int i = 0; i < int'(v.len); i++) begin
            @(negedge clk);
            if (i == 1)               check(v.exp_s, int'(v.rq), "after boundary");
            if (i == int'(v.len) - 1) check(v.exp_e, int'(v.rq), "frame end");
            if (i == int'(v.mod_i))                mem[i % FL] ^= 16'h5A5A;
            if (i == int'(v.hw_i) && v.hw_pre)     mem[i % FL] ^= 16'h0F0F;
            frame_n = (i != 0);
            rd_word = mem[i % FL];
            host_wr = (i == int'(v.hw_i));
            if (i == int'(v.hw_i) && !v.hw_pre)    mem[i % FL] ^= 16'h0F0F;
            ds_n = (i != int'(v.clr_i));
            cs_n = !(i == int'(v.clr_i) && v.clr_cs);
        end
    endtask

    function automatic vec_t plain(input logic es, input logic ee, input logic [7:0] m, input logic [3:0] rq);
        vec_t v;
        v = '{8'd16, m, 8'd255, 1'b0, 8'd255, 1'b0, es, ee, rq};
        return v;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < FL; i++) mem[i] = 16'(i * 16'h1111 + 16'h0007);
        repeat (3) @(negedge clk);
        check(1'b1, 7, "in reset"); // R7
        rst_n = 1'b1;
        junk(5);
        for (int k = 0; k < NV; k++) do_frame(TBL[k]);
        // directed: reset while the flag is low, R7
        @(negedge clk);
        rst_n = 1'b0;
        frame_n = 1'b1;
        @(negedge clk);
        check(1'b1, 7, "reset clears flag");
        rst_n = 1'b1;
        junk(4);
        do_frame(plain(1'b1, 1'b1, 8'd1, 4'd7)); // R7 change vs partial data ignored
        do_frame(plain(1'b1, 1'b1, 8'd255, 4'd7)); // R7 reference loaded
        do_frame(plain(1'b1, 1'b1, 8'd1, 4'd9)); // R9 same image, then flip word 1
        do_frame(plain(1'b0, 1'b0, 8'd255, 4'd2)); // R2 detected again
        finish_run();
    end

    initial begin
        wait (cyc > 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: cycles=%0d expected < 20000", cyc);
        finish_run();
    end

endmodule